// File: doc/BRIEF.md
# CORDIC Double-Precision Divider

This block divides one 64-bit IEEE 754 double-precision value by another and returns the quotient in the same format. The significands are divided by a radix-2 CORDIC engine in linear mode. Each step shifts the divisor right by the step index, then adds it to or subtracts it from a residual. At the same time it adds or subtracts the matching power of two to or from a quotient accumulator. The sign of the residual selects the direction of each step.

Plain linear CORDIC gives a correct quotient only inside a bounded window. Outside that window it saturates to a wrong value, and nothing shows the error until every step has run. To avoid this, an alignment stage first moves the divisor onto a fixed exponent and keeps the difference as a credit exponent. Both significands are then held in [1, 2), so their ratio always falls in (0.5, 2), which lies inside the window. A packing stage adds the credit back, normalizes the quotient, truncates it to 52 fraction bits and handles overflow and underflow.

A one-cycle `start` in the idle state latches both operands and raises `busy`. When the quotient is ready, `done` pulses for one cycle and `result` holds the quotient until the next operation finishes. The controller has five states. IDLE goes to ALIGN on `start`. ALIGN goes to FINISH when the operands form a special case, and to ITER otherwise. ITER stays in ITER until `ITER` steps have run, then goes to PACK. PACK goes to FINISH. FINISH goes to IDLE.

Top module: `cordic_fdiv`

## Requirements
- R1: With the default parameters (`ITER` = 64, `FRAC` = 60), the quotient of two normal operands differs from the exact quotient by a relative error of at most 2^-50, provided the exact quotient is in the normal range.
- R2: The sign bit (bit 63) of every non-NaN result is the XOR of the two operand sign bits.
- R3: Timing of a non-special operation. `busy` is high from the edge after `start` is accepted until `done` rises. `done` is high for exactly one cycle, the cycle after the (`ITER`+3)th rising edge, where the edge that samples `start` counts as the first. `busy` and `done` are never high together.
- R4: `start` is ignored while `busy` or `done` is high. The running operation completes with its original operands, and `result` holds its value while `busy` is high.
- R5: A zero divisor with a finite non-zero dividend, or an infinite dividend with a finite divisor, gives infinity (exponent field 0x7FF, fraction 0) with the R2 sign.
- R6: Any of the following gives exactly 0x7FF8000000000000:
  - a NaN operand (exponent field 0x7FF, fraction non-zero);
  - 0/0;
  - infinity divided by infinity.
- R7: Any of the following gives a signed zero, and `done` rises after the 2nd edge with no iterations:
  - a zero dividend with a non-zero divisor;
  - a finite dividend with an infinite divisor.
- R8: If the biased result exponent reaches 2047 or more, the result is infinity with the R2 sign.
- R9: If the biased result exponent falls to 0 or less, the result is zero with the R2 sign.
- R10: An operand whose exponent field is 0 counts as zero whatever its fraction.
- R11: During and after reset, `busy` and `done` are low and `result` is 0.
- R12: With `ITER` = 16 and `FRAC` = 60, normal quotients have a relative error of at most 2^-12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; accepted only in the idle state |
| dividend | input | 64 | Double-precision numerator Y |
| divisor | input | 64 | Double-precision denominator X |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | 64 | Double-precision quotient Y / X, truncated |

## Verification
The bench builds two copies of the block, and both receive the same operands and `start` pulses. The first uses `ITER` = 64 and `FRAC` = 60. It is checked against the simulator's own real division to the tight tolerance, and against a latency of exactly 67 edges. The second uses `ITER` = 16. Its looser bound over the same operands shows how accuracy grows with the step count, and a 16-step run also exercises a shorter latency. The operand table spans exponents from about 1e-200 to 1e100, which drives the credit exponent to both extremes. Quotients with significand ratio below one exercise the normalization decrement.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int EXP_W  = 11;
    localparam int FRC_W  = 52;
    localparam int BIAS   = 1023;
    localparam int EXP_MAX = 2047;
    localparam logic [63:0] QNAN_VAL = 64'h7FF8_0000_0000_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_ITER,
        ST_PACK,
        ST_FINISH
    } fdiv_state_e;
endpackage

// File: rtl/fdiv_prescale.sv
module fdiv_prescale
    import fdiv_pkg::*;
#(
    parameter int FRAC = 60,
    parameter int W    = FRAC + 3
) (
    input  logic [63:0]        num_in,
    input  logic [63:0]        den_in,
    output logic               special,
    output logic [63:0]        special_val,
    output logic               q_sign,
    output logic signed [12:0] exp_sum,
    output logic [W-1:0]       num_mant,
    output logic [W-1:0]       den_mant
);
    // the divisor is moved onto this exponent; the credit restores the difference
    localparam int EX0 = BIAS;

    logic [EXP_W-1:0] ea, eb;
    logic [FRC_W-1:0] fa, fb;
    logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
    logic signed [12:0] credit;

    always_comb begin
        ea = num_in[62:52];
        eb = den_in[62:52];
        fa = num_in[51:0];
        fb = den_in[51:0];
        q_sign = num_in[63] ^ den_in[63];

        a_zero = (ea == '0);
        b_zero = (eb == '0);
        a_inf  = (ea == '1) && (fa == '0);
        b_inf  = (eb == '1) && (fb == '0);
        a_nan  = (ea == '1) && (fa != '0);
        b_nan  = (eb == '1) && (fb != '0);

        credit  = $signed(13'(EX0)) - $signed({2'b00, eb});
        exp_sum = $signed({2'b00, ea}) - $signed(13'(EX0)) + $signed(13'(BIAS)) + credit;

        num_mant = W'({1'b1, fa}) << (FRAC - FRC_W);
        den_mant = W'({1'b1, fb}) << (FRAC - FRC_W);

        special     = 1'b1;
        special_val = '0;
        if (a_nan || b_nan || (a_zero && b_zero) || (a_inf && b_inf)) begin
            special_val = QNAN_VAL;
        end else if (a_inf || b_zero) begin
            special_val = {q_sign, {EXP_W{1'b1}}, {FRC_W{1'b0}}};
        end else if (a_zero || b_inf) begin
            special_val = {q_sign, 63'b0};
        end else begin
            special = 1'b0;
        end
    end
endmodule

// File: rtl/fdiv_cordic_step.sv
module fdiv_cordic_step #(
    parameter int FRAC  = 60,
    parameter int W     = FRAC + 3,
    parameter int CNT_W = 7
) (
    input  logic signed [W-1:0] y_in,
    input  logic signed [W-1:0] z_in,
    input  logic [W-1:0]        x_in,
    input  logic [CNT_W-1:0]    idx,
    output logic signed [W-1:0] y_out,
    output logic signed [W-1:0] z_out
);
    localparam logic [W-1:0] ONE = {{(W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

    logic signed [W-1:0] x_sh, unit;

    always_comb begin
        x_sh = $signed(x_in >> idx);
        unit = $signed(ONE >> idx);
        if (!y_in[W-1]) begin
            y_out = y_in - x_sh;
            z_out = z_in + unit;
        end else begin
            y_out = y_in + x_sh;
            z_out = z_in - unit;
        end
    end
endmodule

// File: rtl/fdiv_pack.sv
module fdiv_pack
    import fdiv_pkg::*;
#(
    parameter int FRAC = 60,
    parameter int W    = FRAC + 3
) (
    input  logic [W-1:0]       z_in,
    input  logic signed [12:0] exp_sum,
    input  logic               q_sign,
    output logic [63:0]        packed_val
);
    logic [W-1:0]       zn;
    logic [FRC_W-1:0]   frac;
    logic signed [13:0] e;

    always_comb begin
        e = {exp_sum[12], exp_sum};
        if (z_in[FRAC]) begin
            zn = z_in;
        end else begin
            zn = z_in << 1;
            e  = e - 14'sd1;
        end
        frac = FRC_W'(zn >> (FRAC - FRC_W));
        if (e >= $signed(14'(EXP_MAX))) begin
            packed_val = {q_sign, {EXP_W{1'b1}}, {FRC_W{1'b0}}};
        end else if (e <= 14'sd0) begin
            packed_val = {q_sign, 63'b0};
        end else begin
            packed_val = {q_sign, e[EXP_W-1:0], frac};
        end
    end
endmodule

// File: rtl/cordic_fdiv.sv
module cordic_fdiv
    import fdiv_pkg::*;
#(
    parameter int ITER = 64,
    parameter int FRAC = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [63:0] dividend,
    input  logic [63:0] divisor,
    output logic        busy,
    output logic        done,
    output logic [63:0] result
);
    localparam int W     = FRAC + 3;
    localparam int CNT_W = $clog2(ITER + 1);

    fdiv_state_e state, state_nx;

    logic [63:0]        a_q, b_q, res_q;
    logic signed [W-1:0] y_q, z_q, y_nx, z_nx;
    logic [W-1:0]       x_q;
    logic signed [12:0] exp_q;
    logic               sign_q;
    logic [CNT_W-1:0]   cnt_q;

    logic               pre_special, pre_sign;
    logic [63:0]        pre_val, pack_val;
    logic signed [12:0] pre_exp;
    logic [W-1:0]       pre_num, pre_den;

    fdiv_prescale #(.FRAC(FRAC), .W(W)) u_pre (
        .num_in      (a_q),
        .den_in      (b_q),
        .special     (pre_special),
        .special_val (pre_val),
        .q_sign      (pre_sign),
        .exp_sum     (pre_exp),
        .num_mant    (pre_num),
        .den_mant    (pre_den)
    );

    fdiv_cordic_step #(.FRAC(FRAC), .W(W), .CNT_W(CNT_W)) u_step (
        .y_in  (y_q),
        .z_in  (z_q),
        .x_in  (x_q),
        .idx   (cnt_q),
        .y_out (y_nx),
        .z_out (z_nx)
    );

    fdiv_pack #(.FRAC(FRAC), .W(W)) u_pack (
        .z_in       (z_q),
        .exp_sum    (exp_q),
        .q_sign     (sign_q),
        .packed_val (pack_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_ALIGN;
            ST_ALIGN:  state_nx = pre_special ? ST_FINISH : ST_ITER;
            ST_ITER:   if (cnt_q == CNT_W'(ITER - 1)) state_nx = ST_PACK;
            ST_PACK:   state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = (state == ST_ALIGN) || (state == ST_ITER) || (state == ST_PACK);
        done   = (state == ST_FINISH);
        result = res_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            res_q  <= '0;
            y_q    <= '0;
            z_q    <= '0;
            x_q    <= '0;
            exp_q  <= '0;
            sign_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_q <= dividend;
                        b_q <= divisor;
                    end
                end
                ST_ALIGN: begin
                    if (pre_special) res_q <= pre_val;
                    y_q    <= $signed(pre_num);
                    x_q    <= pre_den;
                    z_q    <= '0;
                    exp_q  <= pre_exp;
                    sign_q <= pre_sign;
                    cnt_q  <= '0;
                end
                ST_ITER: begin
                    y_q   <= y_nx;
                    z_q   <= z_nx;
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_PACK: res_q <= pack_val;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        a_sign,
    input logic        b_sign,
    input logic        busy,
    input logic        done,
    input logic [63:0] result
);
    logic exp_sign;
    logic res_nan;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         exp_sign <= 1'b0;
        else if (start && !busy && !done)   exp_sign <= a_sign ^ b_sign;
    end

    assign res_nan = (result[62:52] == 11'h7FF) && (result[51:0] != '0);

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(result) || done));

    a_r2_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !res_nan) |-> (result[63] == exp_sign));
endmodule

bind cordic_fdiv fdiv_checker u_fdiv_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .a_sign (dividend[63]),
    .b_sign (divisor[63]),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/test_cordic_fdiv.sv
module test_cordic_fdiv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] dividend = '0;
    logic [63:0] divisor = '0;
    logic        busy, done, busy_s, done_s;
    logic [63:0] result, result_s, cap_s;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cordic_fdiv #(.ITER(64), .FRAC(60)) i_cordic_fdiv (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .result(result));

    cordic_fdiv #(.ITER(16), .FRAC(60)) i_cordic_fdiv_n16 (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy_s), .done(done_s), .result(result_s));

    always @(negedge clk) if (done_s) cap_s <= result_s;

    localparam int NV = 8;
    localparam real TA [0:NV-1] = '{1.0, 10.0, -7.5, 3.0, 1.0, 1.999, 1.0e-5, -2.5e100};
    localparam real TB [0:NV-1] = '{3.0, 4.0, 0.3, -1.5e-200, 1.0, 1.0000001, 7.0, -3.3e-50};

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic chk_bits(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rel(string req, logic [63:0] act, real exp, real tol);
        real r, err;
        r = $bitstoreal(act);
        err = (r - exp) / exp;
        if (err < 0.0) err = -err;
        n_chk++;
        if (!(err <= tol)) begin
            n_fail++;
            $display("FAIL %s: actual %g (%h) expected %g rel err %g", req, r, act, exp, err);
        end
    endtask

    // issues one operation, returns result and edge count until done
    task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                          output logic [63:0] r, output int edges);
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(posedge clk);
        edges = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && edges < 1000) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        r = result;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R3: watchdog actual no completion expected done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        int ed;
        real q;

        // R11 reset state
        repeat (3) @(negedge clk);
        chk_int("R11 busy in reset", int'(busy), 0);
        chk_int("R11 done in reset", int'(done), 0);
        chk_bits("R11 result in reset", result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_int("R11 busy after reset", int'(busy), 0);
        chk_bits("R11 result after reset", result, 64'h0);

        // table walk: R1 accuracy, R2 sign, R3 latency, R12 short engine
        for (int i = 0; i < NV; i++) begin
            q = TA[i] / TB[i];
            run_op($realtobits(TA[i]), $realtobits(TB[i]), r, ed);
            chk_rel("R1/R2 quotient", r, q, 2.0 ** -50);
            chk_int("R3 latency", ed, 67);
            chk_rel("R12 16-step quotient", cap_s, q, 2.0 ** -12);
        end

        // R3 busy during run, R4 start ignored while busy
        @(negedge clk);
        dividend = $realtobits(6.0);
        divisor  = $realtobits(4.0);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk_int("R3 busy mid-run", int'(busy), 1);
        dividend = $realtobits(-100.0);
        divisor  = $realtobits(3.0);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk_rel("R4 start ignored while busy", result, 1.5, 2.0 ** -50);
        chk_int("R3 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk_int("R3 done single pulse", int'(done), 0);

        // R5 infinities
        run_op($realtobits(5.0), 64'h8000_0000_0000_0000, r, ed);
        chk_bits("R5 x/-0", r, 64'hFFF0_0000_0000_0000);
        run_op(64'h7FF0_0000_0000_0000, $realtobits(2.0), r, ed);
        chk_bits("R5 inf/2", r, 64'h7FF0_0000_0000_0000);

        // R6 quiet NaN
        run_op(64'h0, 64'h0, r, ed);
        chk_bits("R6 0/0", r, 64'h7FF8_0000_0000_0000);
        run_op(64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, r, ed);
        chk_bits("R6 inf/inf", r, 64'h7FF8_0000_0000_0000);
        run_op(64'h7FF0_0000_0000_0001, $realtobits(1.0), r, ed);
        chk_bits("R6 NaN operand", r, 64'h7FF8_0000_0000_0000);

        // R7 zero results without iterating
        run_op(64'h8000_0000_0000_0000, $realtobits(3.0), r, ed);
        chk_bits("R7 -0/3", r, 64'h8000_0000_0000_0000);
        chk_int("R7 early done", ed, 2);
        run_op($realtobits(3.0), 64'hFFF0_0000_0000_0000, r, ed);
        chk_bits("R7 3/-inf", r, 64'h8000_0000_0000_0000);

        // R8 overflow, R9 underflow
        run_op($realtobits(-1.0e300), $realtobits(1.0e-300), r, ed);
        chk_bits("R8 overflow", r, 64'hFFF0_0000_0000_0000);
        run_op($realtobits(1.0e-300), $realtobits(-1.0e300), r, ed);
        chk_bits("R9 underflow", r, 64'h8000_0000_0000_0000);

        // R10 exponent-zero operands are zero
        run_op(64'h0000_0000_0000_0001, $realtobits(2.0), r, ed);
        chk_bits("R10 denormal dividend", r, 64'h0);
        run_op($realtobits(2.0), 64'h000F_FFFF_FFFF_FFFF, r, ed);
        chk_bits("R10 denormal divisor", r, 64'h7FF0_0000_0000_0000);

        finished = 1;
        summary();
        $finish;
    end
endmodule